// File: doc/BRIEF.md
# Page-Write Load Engine for Byte-Alterable Nonvolatile Memory

This block is the device-side write controller of a byte-alterable nonvolatile memory. An asynchronous SRAM-style bus (active-low chip enable, output enable and write enable, a 19-bit address, an 8-bit data path) reaches it and is sampled on the block clock. Write strobes that are long enough and properly qualified become byte loads. The first load locks a page. Later loads to the same page fill a page buffer of up to 2^PAGE_BITS bytes. When no accepted load arrives for a set number of cycles, a self-timed programming phase starts. At the end of that phase, every loaded byte is committed to the storage array in one burst.

While programming and commit run, reads return an in-band status word in place of array data. Bit 7 carries the complement of bit 7 of the last loaded byte. Bit 6 alternates from one read to the next. A host polls with ordinary reads, so no ready pin is needed. The storage array is a plain synchronous RAM of 2^ARRAY_AW bytes indexed by the low address bits. Timing windows are parameters counted in clock cycles.

Top module: `eepw_engine`

## Requirements
- R1: A write strobe opens when ce_n and we_n are both sampled low. It is armed only if oe_n is high when the strobe opens. It is disarmed if oe_n is sampled low in any cycle of the strobe. A strobe with we_n low and ce_n high is not a write.
- R2: A strobe takes its address from the first cycle in which ce_n and we_n are both low, which is the later of the two falling edges. It takes its data from the last cycle before either of them rises, which is the earlier rising edge. Later address or data changes are not used.
- R3: A strobe shorter than MIN_LOW_CYC sampled cycles is discarded. A strobe of exactly MIN_LOW_CYC cycles is accepted.
- R4: The first accepted load locks page bits addr[ADDR_W-1:PAGE_BITS]. Offset bits addr[PAGE_BITS-1:0] select one byte of the page buffer. A repeated offset keeps the newest byte.
- R5: A load whose page bits differ from the locked page is dropped. It writes nothing and does not restart the window.
- R6: Programming starts WINDOW_CYC cycles after the most recent accepted load. Each accepted load restarts this count.
- R7: Programming lasts PROG_CYC cycles and is followed by the commit. The array keeps its old contents until the commit. Afterwards every loaded offset holds its byte, and offsets that were not loaded keep their old value.
- R8: Every write strobe is ignored during programming and commit.
- R9: A read is ce_n and oe_n sampled low. data_oe rises two clock edges after the read is sampled. Outside busy, data_out gives the array byte at addr[ARRAY_AW-1:0], so higher address bits alias.
- R10: During programming and commit, a read returns a status word. Bit 7 is the inverse of bit 7 of the last accepted byte. Bits 5:0 equal that byte's bits 5:0. Bit 6 takes the opposite value on each new read.
- R11: After reset the block is idle, data_oe is low and data_out is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; blocks writes when low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| data_in | input | 8 | Write data from host |
| data_out | output | 8 | Read data or busy status; zero when not driving |
| data_oe | output | 1 | High while data_out is driven |

## Verification
Several properties are checked on every cycle. The locked page stays constant while loads are gathered. The window counter stays below its limit. Buffer and array writes never happen outside their phases. The commit follows programming directly. data_oe is always traceable to a sampled read two edges earlier. Behaviour that depends on what the host does over time can only be shown by the bench scenarios, which compare array contents against the bench's expected values after each commit: strobe qualification, capture of address and data on the proper edges, dropped off-page loads, window restarts, toggling of the status word, and address aliasing.

// File: rtl/eepw_pkg.sv
// Shared types for the page-write load engine.
package eepw_pkg;

    // Phase of the page-write controller.
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOAD   = 2'd1,
        ST_PROG   = 2'd2,
        ST_COMMIT = 2'd3
    } eepw_state_e;

    // Status word returned on reads while programming is in progress.
    function automatic logic [7:0] busy_word(input logic [7:0] last_byte,
                                             input logic       toggle);
        return {~last_byte[7], toggle, last_byte[5:0]};
    endfunction

endpackage

// File: rtl/eepw_strobe.sv
// Bus front end: registers the asynchronous bus once and turns qualified
// write strobes into single-cycle load pulses. It also presents the
// registered read request.
// Assumes: bus inputs are held for at least one clock period per level, and
// MIN_LOW_CYC >= 1.
module eepw_strobe #(
    parameter int ADDR_W      = 19,
    parameter int ARRAY_AW    = 11,
    parameter int MIN_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic              load_vld,
    output logic [ADDR_W-1:0] load_addr,
    output logic [7:0]        load_data,
    output logic              rd_act,
    output logic [ARRAY_AW-1:0] rd_addr
);
    localparam int LEN_W = $clog2(MIN_LOW_CYC + 1);
    localparam logic [LEN_W-1:0] LEN_MIN = LEN_W'(MIN_LOW_CYC);

    logic              ce_q, oe_q, we_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        din_q;
    logic              wr_act, wr_act_d, armed;
    logic [LEN_W-1:0]  len;
    logic [ADDR_W-1:0] cap_addr;
    logic [7:0]        dat_hold;

    // Single sampling stage for every bus input.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_q   <= 1'b1;
            oe_q   <= 1'b1;
            we_q   <= 1'b1;
            addr_q <= '0;
            din_q  <= '0;
        end else begin
            ce_q   <= ce_n;
            oe_q   <= oe_n;
            we_q   <= we_n;
            addr_q <= addr;
            din_q  <= data_in;
        end
    end

    assign wr_act = !ce_q && !we_q;

    // Track one strobe: arm at opening, measure width, emit a load at release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_act_d <= 1'b0;
            armed    <= 1'b0;
            len      <= '0;
            cap_addr <= '0;
            dat_hold <= '0;
            load_vld <= 1'b0;
        end else begin
            wr_act_d <= wr_act;
            load_vld <= 1'b0;
            if (wr_act && !wr_act_d) begin
                armed    <= oe_q;
                cap_addr <= addr_q;
                dat_hold <= din_q;
                len      <= LEN_W'(1);
            end else if (wr_act) begin
                if (!oe_q) begin
                    armed <= 1'b0;
                end
                if (len < LEN_MIN) begin
                    len <= len + LEN_W'(1);
                end
                dat_hold <= din_q;
            end else if (wr_act_d) begin
                if (armed && (len >= LEN_MIN)) begin
                    load_vld <= 1'b1;
                end
                armed <= 1'b0;
            end
        end
    end

    assign load_addr = cap_addr;
    assign load_data = dat_hold;
    assign rd_act    = !ce_q && !oe_q;
    assign rd_addr   = ARRAY_AW'(addr_q);

    // A strobe yields at most one load, never two in a row.
    p_single_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> !load_vld);

endmodule

// File: rtl/eepw_page_buf.sv
// Page buffer: one data byte and one valid flag per page offset.
// Assumes: a clear and a write never happen in the same cycle.
module eepw_page_buf #(
    parameter int PAGE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [PAGE_BITS-1:0] wr_idx,
    input  logic [7:0]           wr_data,
    input  logic                 clr,
    input  logic [PAGE_BITS-1:0] rd_idx,
    output logic [7:0]           rd_data,
    output logic                 rd_valid
);
    localparam int DEPTH = 1 << PAGE_BITS;

    logic [7:0]       slot_data  [DEPTH];
    logic [DEPTH-1:0] slot_valid;

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Valid flag of one slot: set on load, cleared after commit.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) begin
                slot_valid[g] <= 1'b0;
            end else if (wr_en && (wr_idx == PAGE_BITS'(g))) begin
                slot_valid[g] <= 1'b1;
            end
        end

        // Data byte of one slot; newest load wins.
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == PAGE_BITS'(g))) begin
                slot_data[g] <= wr_data;
            end
        end
    end

    assign rd_data  = slot_data[rd_idx];
    assign rd_valid = slot_valid[rd_idx];

endmodule

// File: rtl/eepw_array.sv
// Storage array: single-port-write, single-port-read synchronous RAM.
// Assumes: contents are not reset (nonvolatile model).
module eepw_array #(
    parameter int ARRAY_AW = 11
) (
    input  logic                clk,
    input  logic                we,
    input  logic [ARRAY_AW-1:0] waddr,
    input  logic [7:0]          wdata,
    input  logic [ARRAY_AW-1:0] raddr,
    output logic [7:0]          rdata
);
    localparam int DEPTH = 1 << ARRAY_AW;

    logic [7:0] cells [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= cells[raddr];
    end

endmodule

// File: rtl/eepw_ctrl.sv
// Page-write controller: locks the page on the first load, runs the
// byte-load window, the self-timed programming count and the commit walk
// over the page buffer.
// Assumes: WINDOW_CYC >= 2, PROG_CYC >= 2, PAGE_BITS < ADDR_W.
module eepw_ctrl
    import eepw_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int PAGE_BITS  = 8,
    parameter int ARRAY_AW   = 11,
    parameter int WINDOW_CYC = 10000,
    parameter int PROG_CYC   = 500000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load_vld,
    input  logic [ADDR_W-1:0]    load_addr,
    input  logic [7:0]           load_data,
    input  logic [7:0]           buf_rd_data,
    input  logic                 buf_rd_valid,
    output logic                 buf_we,
    output logic [PAGE_BITS-1:0] buf_idx,
    output logic [7:0]           buf_wdata,
    output logic                 buf_clr,
    output logic [PAGE_BITS-1:0] buf_rd_idx,
    output logic                 arr_we,
    output logic [ARRAY_AW-1:0]  arr_waddr,
    output logic [7:0]           arr_wdata,
    output logic                 busy,
    output logic [7:0]           last_data
);
    localparam int TAG_W = ADDR_W - PAGE_BITS;
    localparam int WIN_W = $clog2(WINDOW_CYC);
    localparam int PRG_W = $clog2(PROG_CYC);
    localparam logic [PAGE_BITS-1:0] IDX_LAST = PAGE_BITS'((1 << PAGE_BITS) - 1);

    eepw_state_e          state;
    logic [TAG_W-1:0]     lock_page;
    logic [WIN_W-1:0]     timer;
    logic [PRG_W-1:0]     pcnt;
    logic [PAGE_BITS-1:0] cidx;
    logic                 page_hit, accept;

    assign page_hit = (load_addr[ADDR_W-1:PAGE_BITS] == lock_page);
    assign accept   = load_vld && ((state == ST_IDLE) || ((state == ST_LOAD) && page_hit));

    // Phase sequencing with window, programming and commit counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            lock_page <= '0;
            timer     <= '0;
            pcnt      <= '0;
            cidx      <= '0;
            last_data <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        lock_page <= load_addr[ADDR_W-1:PAGE_BITS];
                        last_data <= load_data;
                        timer     <= '0;
                        state     <= ST_LOAD;
                    end
                end
                ST_LOAD: begin
                    if (accept) begin
                        last_data <= load_data;
                        timer     <= '0;
                    end else if (timer == WIN_W'(WINDOW_CYC - 1)) begin
                        pcnt  <= '0;
                        state <= ST_PROG;
                    end else begin
                        timer <= timer + WIN_W'(1);
                    end
                end
                ST_PROG: begin
                    if (pcnt == PRG_W'(PROG_CYC - 1)) begin
                        cidx  <= '0;
                        state <= ST_COMMIT;
                    end else begin
                        pcnt <= pcnt + PRG_W'(1);
                    end
                end
                default: begin
                    cidx <= cidx + PAGE_BITS'(1);
                    if (cidx == IDX_LAST) begin
                        state <= ST_IDLE;
                    end
                end
            endcase
        end
    end

    // Load path into the page buffer.
    assign buf_we    = accept;
    assign buf_idx   = load_addr[PAGE_BITS-1:0];
    assign buf_wdata = load_data;

    // Commit path: walk offsets, copy valid bytes, clear on the last one.
    assign buf_rd_idx = cidx;
    assign arr_we     = (state == ST_COMMIT) && buf_rd_valid;
    assign arr_waddr  = ARRAY_AW'({lock_page, cidx});
    assign arr_wdata  = buf_rd_data;
    assign buf_clr    = (state == ST_COMMIT) && (cidx == IDX_LAST);
    assign busy       = (state == ST_PROG) || (state == ST_COMMIT);

    // The locked page never moves while loads are being gathered.
    p_page_locked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LOAD) && ($past(state) == ST_LOAD)) |-> $stable(lock_page));

    // The window counter stays inside its limit.
    p_window_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (int'(timer) < WINDOW_CYC));

    // Commit is entered only straight from programming.
    p_commit_after_prog_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_COMMIT) |-> ($past(state) == ST_PROG));

endmodule

// File: rtl/eepw_engine.sv
// Top of the page-write load engine: bus front end, page buffer, controller,
// storage array and the read/status return path.
// Assumes: ARRAY_AW <= ADDR_W; bus inputs are slow relative to clk.
module eepw_engine
    import eepw_pkg::*;
#(
    parameter int ADDR_W      = 19,
    parameter int PAGE_BITS   = 8,
    parameter int ARRAY_AW    = 11,
    parameter int WINDOW_CYC  = 10000,
    parameter int PROG_CYC    = 500000,
    parameter int MIN_LOW_CYC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        data_in,
    output logic [7:0]        data_out,
    output logic              data_oe
);
    logic                 load_vld, rd_act;
    logic [ADDR_W-1:0]    load_addr;
    logic [7:0]           load_data;
    logic [ARRAY_AW-1:0]  rd_addr;
    logic                 buf_we, buf_clr, buf_rd_valid;
    logic [PAGE_BITS-1:0] buf_idx, buf_rd_idx;
    logic [7:0]           buf_wdata, buf_rd_data;
    logic                 arr_we, busy;
    logic [ARRAY_AW-1:0]  arr_waddr;
    logic [7:0]           arr_wdata, arr_rdata, last_data;
    logic                 busy_seen, tog;

    eepw_strobe #(
        .ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW), .MIN_LOW_CYC(MIN_LOW_CYC)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in),
        .load_vld(load_vld), .load_addr(load_addr), .load_data(load_data),
        .rd_act(rd_act), .rd_addr(rd_addr)
    );

    eepw_page_buf #(.PAGE_BITS(PAGE_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_idx(buf_idx),
        .wr_data(buf_wdata), .clr(buf_clr), .rd_idx(buf_rd_idx),
        .rd_data(buf_rd_data), .rd_valid(buf_rd_valid)
    );

    eepw_ctrl #(
        .ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS), .ARRAY_AW(ARRAY_AW),
        .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .load_vld(load_vld), .load_addr(load_addr),
        .load_data(load_data), .buf_rd_data(buf_rd_data),
        .buf_rd_valid(buf_rd_valid), .buf_we(buf_we), .buf_idx(buf_idx),
        .buf_wdata(buf_wdata), .buf_clr(buf_clr), .buf_rd_idx(buf_rd_idx),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata),
        .busy(busy), .last_data(last_data)
    );

    eepw_array #(.ARRAY_AW(ARRAY_AW)) u_array (
        .clk(clk), .we(arr_we), .waddr(arr_waddr), .wdata(arr_wdata),
        .raddr(rd_addr), .rdata(arr_rdata)
    );

    // Read return: output enable, busy snapshot and per-read status toggle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_oe   <= 1'b0;
            busy_seen <= 1'b0;
            tog       <= 1'b0;
        end else begin
            data_oe   <= rd_act;
            busy_seen <= busy;
            if (rd_act && !data_oe && busy) begin
                tog <= ~tog;
            end
        end
    end

    assign data_out = !data_oe  ? 8'h00 :
                      busy_seen ? busy_word(last_data, tog) : arr_rdata;

    // Output drive is always caused by a read sampled two edges earlier.
    p_drive_needs_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> $past(!ce_n && !oe_n, 2));

    // Nothing enters the page buffer while programming or committing.
    p_busy_blocks_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_we);

    // The array is written only during the busy phase.
    p_array_write_when_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy);

endmodule

// File: tb/test_eepw_engine.sv
// Bench for the page-write load engine in a small configuration:
// 8-byte pages, a 64-byte array, short windows.
module test_eepw_engine;
    localparam int AW = 19;
    localparam int PB = 3;
    localparam int XAW = 6;
    localparam int WIN = 40;
    localparam int PRG = 60;
    localparam int MINL = 3;
    localparam int SETTLE = 130;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    data_in = '0;
    logic [7:0]    data_out;
    logic          data_oe;

    int   n_vec = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;
    logic [7:0] exp_mem [64];

    always #5 clk = ~clk;

    eepw_engine #(
        .ADDR_W(AW), .PAGE_BITS(PB), .ARRAY_AW(XAW),
        .WINDOW_CYC(WIN), .PROG_CYC(PRG), .MIN_LOW_CYC(MINL)
    ) i_eepw_engine (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .data_in(data_in), .data_out(data_out), .data_oe(data_oe)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp_v);
        n_vec++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp_v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [7:0] d, input int low);
        @(negedge clk);
        addr = AW'(a); data_in = d; oe_n = 1'b1; ce_n = 1'b0; we_n = 1'b0;
        repeat (low) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        idle(2);
    endtask

    task automatic rd(input int a, output logic [7:0] v, output logic oe_seen);
        @(negedge clk);
        addr = AW'(a); ce_n = 1'b0; oe_n = 1'b0;
        idle(3);
        v = data_out; oe_seen = data_oe;
        ce_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd_chk(input string req, input int a);
        logic [7:0] v;
        logic o;
        rd(a, v, o);
        chk(req, v, exp_mem[a % 64]);
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'(((a * 29) + 17) ^ 8'h5A);
    endfunction

    // Watchdog: a hung run is counted as a failure and still summarised.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_vec++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v1, v2;
        logic o1;

        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R11: reset state at the ports
        chk("R11 data_oe", {7'b0, data_oe}, 8'h00);
        chk("R11 data_out", data_out, 8'h00);

        // R4 R7 R9: fill every page, one window per page, read all back
        for (int p = 0; p < 8; p++) begin
            for (int o = 0; o < 8; o++) begin
                wr(p * 8 + o, pat(p * 8 + o), 4);
                exp_mem[p * 8 + o] = pat(p * 8 + o);
            end
            idle(SETTLE);
        end
        for (int a = 0; a < 64; a++) rd_chk("R7 fill", a);

        // R4 overwrite, R7 partial page, R10 status, R8 busy write
        wr(16, 8'h3C, 4);
        wr(16, 8'hC4, 4);
        wr(18, 8'h27, 4);
        wr(20, 8'h81, 4);
        wr(22, 8'h6B, 4);
        idle(25);
        rd_chk("R7 array unchanged in window", 22);
        idle(20);
        rd(22, v1, o1);
        rd(22, v2, o1);
        chk("R10 status bits", {1'b0, v1[7], v1[5:0]}, {1'b0, ~8'h6B >> 7 & 1'b1, 6'h2B});
        chk("R10 toggle", {7'b0, v1[6] ^ v2[6]}, 8'h01);
        wr(17, 8'hC3, 4);       // R8: lands in programming, must be dropped
        idle(SETTLE);
        exp_mem[16] = 8'hC4; exp_mem[18] = 8'h27; exp_mem[20] = 8'h81; exp_mem[22] = 8'h6B;
        for (int a = 16; a < 24; a++) rd_chk("R4 R7 R8 page 2", a);

        // R6: window restarts on every accepted load
        wr(40, 8'h10, 4);
        idle(28);
        wr(41, 8'h20, 4);
        idle(28);
        wr(42, 8'h30, 4);
        idle(SETTLE);
        exp_mem[40] = 8'h10; exp_mem[41] = 8'h20; exp_mem[42] = 8'h30;
        for (int a = 40; a < 44; a++) rd_chk("R6 window restart", a);

        // R5: off-page loads are dropped and do not extend the window
        wr(51, 8'hD7, 4);
        for (int i = 0; i < 4; i++) begin
            wr(11, 8'(8'h0F + i), 4);
            idle(6);
        end
        rd(51, v1, o1);
        chk("R5 window not restarted", {1'b0, v1[7], v1[5:0]}, {1'b0, 1'b0, 6'h17});
        idle(SETTLE);
        exp_mem[51] = 8'hD7;
        rd_chk("R5 locked page byte", 51);
        rd_chk("R5 other page untouched", 11);

        // R3: short strobe dropped, exact minimum accepted
        wr(24, 8'hA5, MINL - 1);
        wr(25, 8'hA6, MINL);
        idle(SETTLE);
        exp_mem[25] = 8'hA6;
        rd_chk("R3 short strobe", 24);
        rd_chk("R3 minimum strobe", 25);

        // R1: output enable low throughout, falling mid-strobe, ce high
        @(negedge clk);
        addr = AW'(32); data_in = 8'hE1; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        idle(5);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        idle(2);
        addr = AW'(33); data_in = 8'hE2; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        oe_n = 1'b0;
        idle(2);
        oe_n = 1'b1;
        idle(1);
        ce_n = 1'b1; we_n = 1'b1;
        idle(2);
        addr = AW'(34); data_in = 8'hE3; we_n = 1'b0;
        idle(5);
        we_n = 1'b1;
        idle(SETTLE);
        for (int a = 32; a < 35; a++) rd_chk("R1 blocked strobe", a);

        // R2: capture edges for address and data
        @(negedge clk);
        addr = AW'(56); data_in = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        idle(2);
        addr = AW'(61); data_in = 8'h99;
        idle(2);
        ce_n = 1'b1; we_n = 1'b1;
        idle(2);
        addr = AW'(62); data_in = 8'h33; we_n = 1'b0;
        idle(2);
        addr = AW'(58); data_in = 8'h44; ce_n = 1'b0;
        idle(4);
        ce_n = 1'b1; we_n = 1'b1;
        idle(2);
        addr = AW'(57); data_in = 8'h55; ce_n = 1'b0; we_n = 1'b0;
        idle(4);
        we_n = 1'b1; data_in = 8'h66;
        idle(1);
        ce_n = 1'b1;
        idle(SETTLE);
        exp_mem[56] = 8'h99; exp_mem[58] = 8'h44; exp_mem[57] = 8'h55;
        rd_chk("R2 address at later fall", 56);
        rd_chk("R2 late address unused", 61);
        rd_chk("R2 chip-enable controlled", 58);
        rd_chk("R2 address before chip enable", 62);
        rd_chk("R2 data at earlier rise", 57);

        // R9: aliasing of high address bits, drive timing
        wr(32'h40000 | 7, 8'h7E, 4);
        idle(SETTLE);
        exp_mem[7] = 8'h7E;
        rd_chk("R9 alias low address", 7);
        rd(32'h7FFC0 | 7, v1, o1);
        chk("R9 alias high address", v1, 8'h7E);
        chk("R9 data_oe during read", {7'b0, o1}, 8'h01);
        idle(3);
        chk("R9 data_oe after read", {7'b0, data_oe}, 8'h00);
        chk("R9 data_out idle", data_out, 8'h00);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule